// File: doc/BRIEF.md
# Row-Serial Hamming Syndrome Checker

This block checks a 7-bit received codeword against a parity-check matrix that can be changed at run time. The codeword is systematic: bits [6:3] carry the four information bits and bits [2:0] carry the three parity bits. The matrix has three 7-bit rows, and each row sits in its own register. A small controller captures the codeword and then drives one matrix row per cycle onto a shared row bus. In that cycle it forms one syndrome bit as the mod-2 inner product of the row and the stored word.

When all three syndrome bits are collected, the block reports its verdict as a single-cycle result. A zero syndrome means the word is accepted and its information slice is presented. Any other syndrome means the word is rejected, the information output is forced to zero, and a retransmit request is pulsed. The sender is then expected to offer the word again through the same input handshake, and the register is rewritten before checking starts over. The block does not correct errors.

Top module: `hamming_row_checker`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns after that edge to `cw_ready`=1 with `result_valid`, `error`, `data` and `retransmit_req` all 0, and the matrix rows return to row0=7'b1011001, row1=7'b1101010, row2=7'b1110100.
- R2: A codeword is captured on an edge where `cw_valid` and `cw_ready` are both 1. `cw_ready` then stays 0 for the next four cycles and returns to 1 together with the result.
- R3: `result_valid` goes high for exactly one cycle, after the fourth clock edge that follows the capturing edge.
- R4: Syndrome bit k is the XOR of (row k AND codeword), and row k is sampled on the (k+1)-th edge after capture. `error` is 1 exactly when any syndrome bit is 1. `error` and `data` hold their values until the next result.
- R5: With a zero syndrome, `data` equals codeword bits [6:3].
- R6: With a nonzero syndrome, `data` is 0 and `retransmit_req` is 1 in the same cycle as `result_valid`. A word sent again after this is checked afresh.
- R7: On an edge with `h_load`=1, row `h_row` takes `h_data`, with index 0, 1 or 2 selecting row 0, 1 or 2. A write with index 3 is ignored.
- R8: Matrix rows keep their values across any number of codewords until they are written or reset.
- R9: With the reset matrix, every single-bit flip of a valid codeword, at any of the seven positions, is reported as an error.
- R10: Rows are scanned in the order 0, 1, 2, one row per cycle, and exactly one row drives the row bus while the scan runs.
- R11: `cw_valid` has no effect while `cw_ready` is 0, and the stored codeword is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_load | input | 1 | Write strobe for a matrix row |
| h_row | input | 2 | Index of the row to write (3 is ignored) |
| h_data | input | 7 | New row contents |
| cw_valid | input | 1 | Codeword offered |
| cw_data | input | 7 | Codeword: [6:3] information, [2:0] parity |
| cw_ready | output | 1 | Block is idle and will accept a codeword |
| result_valid | output | 1 | One-cycle verdict strobe |
| error | output | 1 | Nonzero syndrome for the last word |
| data | output | 4 | Information bits of the last accepted word, 0 on error |
| retransmit_req | output | 1 | One-cycle request to send the word again |

## Verification
A controller that skips, repeats or misorders a row scan produces a wrong verdict. It also pulses `result_valid` early or late, and either shows at the ports within five cycles of capture. A corrupted matrix row or a lost row write stays hidden until a codeword that depends on that column is checked. For this reason the bench re-runs words after every row change, and after a write to index 3. A stored codeword that is overwritten while busy shows up as wrong `data` on the very next result.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

    typedef enum logic [1:0] {
        HSC_IDLE = 2'd0,
        HSC_SCAN = 2'd1,
        HSC_DONE = 2'd2
    } hsc_state_e;

endpackage

// File: rtl/hsc_dot.sv
module hsc_dot #(
    parameter int W = 7
) (
    input  logic [W-1:0] row_vec,
    input  logic [W-1:0] word_vec,
    output logic         parity_bit
);

    always_comb begin
        parity_bit = ^(row_vec & word_vec);
    end

endmodule

// File: rtl/hsc_row_bank.sv
module hsc_row_bank #(
    parameter int CW_W  = 7,
    parameter int ROWS  = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CW_W-1:0]  wr_data,
    input  logic [ROWS-1:0]  row_sel,
    output logic [CW_W-1:0]  row_bus
);

    logic [CW_W-1:0] rows_d [ROWS];
    logic [CW_W-1:0] rows_q [ROWS];

    // Standard check row: identity on the parity part, and successive
    // non-power-of-two codes on the information columns.
    function automatic logic [CW_W-1:0] std_row(input int r);
        logic [CW_W-1:0] v;
        int code;
        v    = CW_W'(1) << r;
        code = 3;
        for (int c = ROWS; c < CW_W; c++) begin
            for (int k = 0; k < 4; k++) begin
                if ((code & (code - 1)) == 0) code++;
            end
            if (((code >> r) & 1) == 1) v = v | (CW_W'(1) << c);
            code++;
        end
        return v;
    endfunction

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            rows_d[r] = rows_q[r];
            if (wr_en && (int'(wr_idx) == r)) rows_d[r] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (rst) rows_q[r] <= std_row(r);
            else     rows_q[r] <= rows_d[r];
        end
    end

    // AND-OR multiplexer onto the shared row bus
    always_comb begin
        row_bus = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_sel[r]) row_bus = row_bus | rows_q[r];
        end
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_wr_chk
        assert_row_write_R7: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (int'(wr_idx) == g)) |=> (rows_q[g] == $past(wr_data)));
        assert_row_keep_R8: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (int'(wr_idx) == g)) |=> $stable(rows_q[g]));
    end

endmodule

// File: rtl/hsc_ctrl.sv
module hsc_ctrl
    import hsc_pkg::*;
#(
    parameter int CW_W   = 7,
    parameter int INFO_W = 4,
    parameter int ROWS   = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cw_valid,
    input  logic [CW_W-1:0]   cw_data,
    input  logic              syn_bit,
    output logic              cw_ready,
    output logic [ROWS-1:0]   row_sel,
    output logic [CW_W-1:0]   cw_word,
    output logic              res_valid,
    output logic              res_err,
    output logic [INFO_W-1:0] res_data,
    output logic              retx
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(ROWS - 1);

    typedef struct packed {
        hsc_state_e        state;
        logic [IDX_W-1:0]  row;
        logic [ROWS-1:0]   syn;
        logic [CW_W-1:0]   cw;
        logic              rv;
        logic              err;
        logic [INFO_W-1:0] data;
        logic              retx;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rv   = 1'b0;
        st_d.retx = 1'b0;
        case (st_q.state)
            HSC_IDLE: begin
                if (cw_valid) begin
                    st_d.cw    = cw_data;
                    st_d.row   = '0;
                    st_d.state = HSC_SCAN;
                end
            end
            HSC_SCAN: begin
                st_d.syn[st_q.row] = syn_bit;
                if (st_q.row == LAST_ROW) st_d.state = HSC_DONE;
                else                      st_d.row   = st_q.row + 1'b1;
            end
            HSC_DONE: begin
                st_d.rv    = 1'b1;
                st_d.err   = |st_q.syn;
                st_d.retx  = |st_q.syn;
                st_d.data  = (|st_q.syn) ? '0 : st_q.cw[CW_W-1 -: INFO_W];
                st_d.state = HSC_IDLE;
            end
            default: st_d.state = HSC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        cw_ready  = (st_q.state == HSC_IDLE);
        row_sel   = (st_q.state == HSC_SCAN) ? (ROWS'(1) << st_q.row) : '0;
        cw_word   = st_q.cw;
        res_valid = st_q.rv;
        res_err   = st_q.err;
        res_data  = st_q.data;
        retx      = st_q.retx;
    end

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_ready) |=> !cw_ready);
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    assert_after_last_R3: assert property (@(posedge clk) disable iff (rst)
        row_sel[ROWS-1] |=> (row_sel == '0) ##1 res_valid);
    assert_retx_err_R6: assert property (@(posedge clk) disable iff (rst)
        retx |-> (res_valid && res_err));
    assert_err_data_zero_R6: assert property (@(posedge clk) disable iff (rst)
        res_err |-> (res_data == '0));
    assert_scan_order_R10: assert property (@(posedge clk) disable iff (rst)
        ((row_sel != '0) && !row_sel[ROWS-1]) |=> (row_sel == ($past(row_sel) << 1)));
    assert_capture_start_R10: assert property (@(posedge clk) disable iff (rst)
        (cw_valid && cw_ready) |=> (row_sel == ROWS'(1)));
    assert_word_held_R11: assert property (@(posedge clk) disable iff (rst)
        !cw_ready |=> $stable(cw_word));

endmodule

// File: rtl/hamming_row_checker.sv
module hamming_row_checker #(
    parameter  int CW_W   = 7,
    parameter  int INFO_W = 4,
    localparam int ROWS   = CW_W - INFO_W,
    localparam int IDX_W  = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_load,
    input  logic [IDX_W-1:0]  h_row,
    input  logic [CW_W-1:0]   h_data,
    input  logic              cw_valid,
    input  logic [CW_W-1:0]   cw_data,
    output logic              cw_ready,
    output logic              result_valid,
    output logic              error,
    output logic [INFO_W-1:0] data,
    output logic              retransmit_req
);

    logic [ROWS-1:0] row_sel;
    logic [CW_W-1:0] row_bus;
    logic [CW_W-1:0] cw_word;
    logic            syn_bit;

    hsc_row_bank #(
        .CW_W  (CW_W),
        .ROWS  (ROWS),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (h_load),
        .wr_idx  (h_row),
        .wr_data (h_data),
        .row_sel (row_sel),
        .row_bus (row_bus)
    );

    hsc_dot #(
        .W (CW_W)
    ) u_dot (
        .row_vec    (row_bus),
        .word_vec   (cw_word),
        .parity_bit (syn_bit)
    );

    hsc_ctrl #(
        .CW_W   (CW_W),
        .INFO_W (INFO_W),
        .ROWS   (ROWS),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cw_valid  (cw_valid),
        .cw_data   (cw_data),
        .syn_bit   (syn_bit),
        .cw_ready  (cw_ready),
        .row_sel   (row_sel),
        .cw_word   (cw_word),
        .res_valid (result_valid),
        .res_err   (error),
        .res_data  (data),
        .retx      (retransmit_req)
    );

    assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
        !cw_ready |-> $onehot0(row_sel));
    assert_ready_on_result_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(result_valid) |-> cw_ready);

endmodule

// File: tb/hamming_row_checker_test.sv
module hamming_row_checker_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_load = 1'b0;
    logic [1:0] h_row = '0;
    logic [6:0] h_data = '0;
    logic       cw_valid = 1'b0;
    logic [6:0] cw_data = '0;
    logic       cw_ready, result_valid, error, retransmit_req;
    logic [3:0] data;

    int total = 0;
    int fails = 0;
    bit finished = 0;
    bit started = 0;

    localparam logic [6:0] DEF0 = 7'b1011001;
    localparam logic [6:0] DEF1 = 7'b1101010;
    localparam logic [6:0] DEF2 = 7'b1110100;

    hamming_row_checker uut (
        .clk(clk), .rst(rst), .h_load(h_load), .h_row(h_row), .h_data(h_data),
        .cw_valid(cw_valid), .cw_data(cw_data), .cw_ready(cw_ready),
        .result_valid(result_valid), .error(error), .data(data),
        .retransmit_req(retransmit_req)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [6:0] m_h [3];
    logic [6:0] m_cw;
    logic [2:0] m_syn;
    int  m_cnt;
    bit  m_busy, m_rv, m_err, m_retx;
    logic [3:0] m_data;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_rv = 0; m_err = 0; m_retx = 0; m_data = '0;
            m_syn = '0; m_cw = '0;
            m_h[0] = DEF0; m_h[1] = DEF1; m_h[2] = DEF2;
        end else begin
            m_rv = 0; m_retx = 0;
            if (m_busy) begin
                if (m_cnt > 1) m_syn[4-m_cnt] = ^(m_h[4-m_cnt] & m_cw);
                else begin
                    m_rv = 1; m_err = (m_syn != 0); m_retx = m_err;
                    m_data = m_err ? 4'd0 : m_cw[6:3];
                    m_busy = 0;
                end
                m_cnt--;
            end else if (cw_valid) begin
                m_busy = 1; m_cnt = 4; m_cw = cw_data;
            end
            if (h_load && h_row != 2'd3) m_h[h_row] = h_data;
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2", "model cw_ready", int'(cw_ready), int'(!m_busy));
            chk("R3", "model result_valid", int'(result_valid), int'(m_rv));
            chk("R4", "model error", int'(error), int'(m_err));
            chk("R5", "model data", int'(data), int'(m_data));
            chk("R6", "model retransmit_req", int'(retransmit_req), int'(m_retx));
        end
    end

    function automatic logic [6:0] enc(input logic [3:0] info);
        return {info, ^(DEF2[6:3] & info), ^(DEF1[6:3] & info), ^(DEF0[6:3] & info)};
    endfunction

    task automatic load_row(input logic [1:0] r, input logic [6:0] d);
        @(negedge clk);
        h_load = 1'b1; h_row = r; h_data = d;
        @(negedge clk);
        h_load = 1'b0;
    endtask

    // Send a word, optionally poke cw_valid while busy, then check the verdict
    task automatic send(input string tag, input logic [6:0] w, input bit exp_err,
                        input logic [3:0] exp_data, input bit poke);
        @(negedge clk);
        while (!cw_ready) @(negedge clk);
        cw_valid = 1'b1; cw_data = w;
        @(negedge clk);
        cw_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R2", "cw_ready while busy", int'(cw_ready), 0);
            if (poke && i == 0) begin
                cw_valid = 1'b1; cw_data = ~w;
            end else begin
                cw_valid = 1'b0;
            end
            chk("R3", "early result_valid", int'(result_valid), 0);
            @(negedge clk);
        end
        cw_valid = 1'b0;
        chk("R2", "cw_ready at last scan", int'(cw_ready), 0);
        @(negedge clk);
        chk(tag, "result_valid", int'(result_valid), 1);
        chk(tag, "error", int'(error), int'(exp_err));
        chk(tag, "data", int'(data), int'(exp_data));
        chk(tag, "retransmit_req", int'(retransmit_req), int'(exp_err));
        chk("R2", "cw_ready with result", int'(cw_ready), 1);
        @(negedge clk);
        chk("R3", "result_valid pulse width", int'(result_valid), 0);
        chk("R4", "error held", int'(error), int'(exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "cw_ready in reset", int'(cw_ready), 1);
        chk("R1", "result_valid in reset", int'(result_valid), 0);
        chk("R1", "error in reset", int'(error), 0);
        chk("R1", "data in reset", int'(data), 0);
        chk("R1", "retransmit_req in reset", int'(retransmit_req), 0);
        rst = 1'b0;

        // R5: every information value with the reset matrix (R1 rows)
        for (int v = 0; v < 16; v++) send("R5", enc(4'(v)), 1'b0, 4'(v), 1'b0);

        // R9: every single-bit flip is flagged
        for (int b = 0; b < 7; b++) send("R9", enc(4'hB) ^ (7'd1 << b), 1'b1, 4'd0, 1'b0);

        // R6: error then retransmission of the clean word
        send("R6", enc(4'h5) ^ 7'b0010000, 1'b1, 4'd0, 1'b0);
        send("R6", enc(4'h5), 1'b0, 4'h5, 1'b0);

        // R11: cw_valid while busy is ignored
        send("R11", enc(4'h9), 1'b0, 4'h9, 1'b1);
        send("R11", enc(4'h3), 1'b0, 4'h3, 1'b0);

        // R7: clear all rows, every word passes
        load_row(2'd0, 7'd0); load_row(2'd1, 7'd0); load_row(2'd2, 7'd0);
        send("R7", 7'b1010101, 1'b0, 4'b1010, 1'b0);
        // R7: index 3 ignored
        load_row(2'd3, 7'h7F);
        send("R7", 7'b0110011, 1'b0, 4'b0110, 1'b0);
        // R8: rows persist across words
        send("R8", 7'b1111111, 1'b0, 4'hF, 1'b0);
        // R4: one custom row decides the verdict
        load_row(2'd1, 7'b0000010);
        send("R4", 7'b0000010, 1'b1, 4'd0, 1'b0);
        send("R4", 7'b1100101, 1'b0, 4'b1100, 1'b0);
        load_row(2'd2, 7'b1000000);
        send("R4", 7'b1000000, 1'b1, 4'd0, 1'b0);

        // R1: reset restores the standard rows
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", "data after reset", int'(data), 0);
        send("R1", enc(4'hE), 1'b0, 4'hE, 1'b0);
        send("R1", enc(4'hE) ^ 7'b0000100, 1'b1, 4'd0, 1'b0);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL R3 watchdog expired actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule